// File: doc/BRIEF.md
# Four-Lane Integer Vector ALU

This block applies one integer operation to four 32-bit lanes at once. Each request carries three source vectors and an opcode. The lane named x occupies bits 31:0 of every vector, y occupies bits 63:32, z occupies bits 95:64 and w occupies bits 127:96. The operation set covers the following groups:

- wrapping arithmetic: add, multiply and multiply-add
- bitwise logic
- signed and unsigned minimum and maximum
- three kinds of shift
- a per-lane select
- absolute value
- absolute difference with accumulate

A request is marked by a valid strobe. Its result appears in a register one clock later, together with a matching valid flag. The result register holds its last value until the next valid request arrives. A shader-style execution pipeline uses the block as its integer stage. The lane width, the lane count and the shifter structure are parameters.

Top module: `vec_int_alu`

## Requirements
- R1: Opcode 0 (add) returns, per lane, the low 32 bits of src_a + src_b. No carry passes between lanes.
- R2: Opcode 1 (multiply) returns the low 32 bits of src_a * src_b per lane. Opcode 2 (multiply-add) returns the low 32 bits of (src_a * src_b) + src_c per lane. Both give the same bits whether the operands are read as signed or unsigned.
- R3: The bitwise opcodes work per lane:
  - opcode 3 returns ~src_a
  - opcode 4 returns src_a & src_b
  - opcode 5 returns src_a | src_b
  - opcode 6 returns src_a ^ src_b
- R4: The minimum and maximum opcodes compare each lane of src_a with the same lane of src_b:
  - opcode 7 returns the signed minimum
  - opcode 8 returns the signed maximum
  - opcode 9 returns the unsigned minimum
  - opcode 10 returns the unsigned maximum
- R5: The shift opcodes are 11 (left), 12 (arithmetic right) and 13 (logical right). They shift every lane of src_a by bits 4:0 of the x lane of src_b. The other bits and the other lanes of src_b have no effect, so an amount of 32 or more wraps modulo 32.
- R6: An arithmetic right shift fills with copies of the lane's bit 31. A logical right shift fills with zeros.
- R7: Opcode 14 (select) returns the src_b lane where the src_a lane is nonzero. Where the src_a lane is zero, it returns the src_c lane.
- R8: Opcode 15 returns the absolute value of each lane, read as a signed number. 0x80000000 gives 0x80000000.
- R9: Opcode 16 returns, per lane, the low 32 bits of the unsigned absolute difference |src_a - src_b| plus src_c.
- R10: Opcodes 17 to 31 are unused and return zero in every lane.
- R11: out_valid in a cycle equals in_valid from the cycle before. The result of a request is visible one clock after it is presented.
- R12: Reset clears out_valid and result to zero. While in_valid is low, result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| opcode | input | 5 | Operation select (encoding in R1 to R10) |
| src_a | input | 128 | First source vector, lane x in bits 31:0 |
| src_b | input | 128 | Second source vector; its x lane also gives the shift amount |
| src_c | input | 128 | Third source vector (addend or select alternative) |
| out_valid | output | 1 | High one cycle after an accepted request |
| result | output | 128 | Registered result vector |

## Verification
Two functions share a single cycle in this block: the shift amount, which is read from the x lane of src_b, and the per-lane data of src_b, which the same request carries. The bench provokes this with shift requests in which the other lanes of src_b hold unrelated large values and the x lane holds an amount of 32 or more. It judges each lane against a bench model that takes only bits 4:0 of the x lane as the amount. The second overlap is the register's load and hold behaviour. A valid request is followed by an idle cycle, and the bench checks that the idle cycle leaves the result unchanged while out_valid drops.

// File: rtl/vec_alu_pkg.sv
package vec_alu_pkg;

   localparam int OPC_W = 5;

   typedef enum logic [OPC_W-1:0] {
      OP_ADD  = 5'd0,
      OP_MUL  = 5'd1,
      OP_MAD  = 5'd2,
      OP_NOT  = 5'd3,
      OP_AND  = 5'd4,
      OP_OR   = 5'd5,
      OP_XOR  = 5'd6,
      OP_SMIN = 5'd7,
      OP_SMAX = 5'd8,
      OP_UMIN = 5'd9,
      OP_UMAX = 5'd10,
      OP_SHL  = 5'd11,
      OP_SAR  = 5'd12,
      OP_SHR  = 5'd13,
      OP_SEL  = 5'd14,
      OP_ABS  = 5'd15,
      OP_SAD  = 5'd16
   } alu_op_t;

   // Shifter structure choices
   localparam int SHIFT_OPERATOR = 0;
   localparam int SHIFT_LOG_STAGE = 1;

endpackage

// File: rtl/vec_alu_shift.sv
module vec_alu_shift #(
   parameter int LANE_W = 32,
   parameter int IMPL   = 1,
   localparam int AMT_W = $clog2(LANE_W)
) (
   input  logic [LANE_W-1:0] data,
   input  logic [AMT_W-1:0]  amount,
   input  logic              arith,
   output logic [LANE_W-1:0] left,
   output logic [LANE_W-1:0] right
);

   if (IMPL != vec_alu_pkg::SHIFT_OPERATOR && IMPL != vec_alu_pkg::SHIFT_LOG_STAGE) begin : g_bad_impl
      $error("vec_alu_shift: IMPL must select a known shifter");
   end

   logic fill;
   assign fill = arith & data[LANE_W-1];

   if (IMPL == vec_alu_pkg::SHIFT_OPERATOR) begin : g_operator
      logic signed [LANE_W:0] ext;
      logic signed [LANE_W:0] ext_sh;
      assign ext    = {fill, data};
      assign ext_sh = ext >>> amount;
      assign left   = data << amount;
      assign right  = ext_sh[LANE_W-1:0];
   end else begin : g_log_stage
      logic [LANE_W-1:0] stg_l [AMT_W+1];
      logic [LANE_W-1:0] stg_r [AMT_W+1];
      assign stg_l[0] = data;
      assign stg_r[0] = data;
      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         localparam int D = 1 << s;
         assign stg_l[s+1] = amount[s] ? {stg_l[s][LANE_W-1-D:0], {D{1'b0}}} : stg_l[s];
         assign stg_r[s+1] = amount[s] ? {{D{fill}}, stg_r[s][LANE_W-1:D]} : stg_r[s];
      end
      assign left  = stg_l[AMT_W];
      assign right = stg_r[AMT_W];
   end

endmodule

// File: rtl/vec_alu_arith.sv
module vec_alu_arith #(
   parameter int LANE_W = 32
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic [LANE_W-1:0] c,
   output logic [LANE_W-1:0] sum,
   output logic [LANE_W-1:0] prod,
   output logic [LANE_W-1:0] prod_acc,
   output logic [LANE_W-1:0] abs_val,
   output logic [LANE_W-1:0] abs_diff_acc
);

   logic [LANE_W-1:0] diff;

   always_comb begin
      sum          = a + b;
      prod         = a * b;
      prod_acc     = prod + c;
      abs_val      = a[LANE_W-1] ? ({LANE_W{1'b0}} - a) : a;
      diff         = (a >= b) ? (a - b) : (b - a);
      abs_diff_acc = diff + c;
   end

endmodule

// File: rtl/vec_alu_lane.sv
module vec_alu_lane
   import vec_alu_pkg::*;
#(
   parameter int LANE_W     = 32,
   parameter int SHIFT_IMPL = SHIFT_LOG_STAGE,
   localparam int AMT_W     = $clog2(LANE_W)
) (
   input  alu_op_t           op,
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic [LANE_W-1:0] c,
   input  logic [AMT_W-1:0]  amount,
   output logic [LANE_W-1:0] y
);

   logic [LANE_W-1:0] sum, prod, prod_acc, abs_val, abs_diff_acc;
   logic [LANE_W-1:0] sh_left, sh_right;
   logic              lt_s, lt_u;

   vec_alu_arith #(.LANE_W(LANE_W)) u_arith (
      .a(a), .b(b), .c(c),
      .sum(sum), .prod(prod), .prod_acc(prod_acc),
      .abs_val(abs_val), .abs_diff_acc(abs_diff_acc)
   );

   vec_alu_shift #(.LANE_W(LANE_W), .IMPL(SHIFT_IMPL)) u_shift (
      .data(a), .amount(amount), .arith(op == OP_SAR),
      .left(sh_left), .right(sh_right)
   );

   assign lt_s = $signed(a) < $signed(b);
   assign lt_u = a < b;

   always_comb begin
      case (op)
         OP_ADD:  y = sum;
         OP_MUL:  y = prod;
         OP_MAD:  y = prod_acc;
         OP_NOT:  y = ~a;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_SMIN: y = lt_s ? a : b;
         OP_SMAX: y = lt_s ? b : a;
         OP_UMIN: y = lt_u ? a : b;
         OP_UMAX: y = lt_u ? b : a;
         OP_SHL:  y = sh_left;
         OP_SAR:  y = sh_right;
         OP_SHR:  y = sh_right;
         OP_SEL:  y = (a != '0) ? b : c;
         OP_ABS:  y = abs_val;
         OP_SAD:  y = abs_diff_acc;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/vec_int_alu.sv
module vec_int_alu
   import vec_alu_pkg::*;
#(
   parameter int LANE_W     = 32,
   parameter int LANES      = 4,
   parameter int SHIFT_IMPL = SHIFT_LOG_STAGE,
   localparam int VEC_W     = LANE_W * LANES,
   localparam int AMT_W     = $clog2(LANE_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [OPC_W-1:0] opcode,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [VEC_W-1:0] src_c,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);

   if (LANE_W < 8 || (1 << AMT_W) != LANE_W) begin : g_bad_width
      $error("vec_int_alu: LANE_W must be a power of two of at least 8");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("vec_int_alu: LANES must be at least one");
   end

   alu_op_t           op;
   logic [AMT_W-1:0]  amount;
   logic [VEC_W-1:0]  next_res;

   assign op     = alu_op_t'(opcode);
   assign amount = src_b[AMT_W-1:0];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      vec_alu_lane #(.LANE_W(LANE_W), .SHIFT_IMPL(SHIFT_IMPL)) u_lane (
         .op(op),
         .a(src_a[l*LANE_W +: LANE_W]),
         .b(src_b[l*LANE_W +: LANE_W]),
         .c(src_c[l*LANE_W +: LANE_W]),
         .amount(amount),
         .y(next_res[l*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end

   // Output register checks
   assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   assert_zero_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == OP_SHL && src_b[AMT_W-1:0] == '0) |=> result == $past(src_a));

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      assert_lane_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == OP_ADD) |=>
         result[l*LANE_W +: LANE_W] == $past(src_a[l*LANE_W +: LANE_W] + src_b[l*LANE_W +: LANE_W]));
      assert_lane_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == OP_SEL && src_a[l*LANE_W +: LANE_W] == '0) |=>
         result[l*LANE_W +: LANE_W] == $past(src_c[l*LANE_W +: LANE_W]));
   end

endmodule

// File: tb/sim_vec_int_alu.sv
module sim_vec_int_alu;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [4:0]   opcode = '0;
   logic [127:0] src_a = '0, src_b = '0, src_c = '0;
   logic         out_valid;
   logic [127:0] result;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_int_alu u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .src_a(src_a), .src_b(src_b), .src_c(src_c),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [31:0] ref_lane(int op, logic [31:0] a, logic [31:0] b,
                                            logic [31:0] c, logic [4:0] s);
      logic [31:0] r;
      logic [63:0] wide;
      case (op)
         0: r = a + b;
         1: begin wide = {32'd0, a} * {32'd0, b}; r = wide[31:0]; end
         2: begin wide = {32'd0, a} * {32'd0, b}; r = wide[31:0] + c; end
         3: r = ~a;
         4: r = a & b;
         5: r = a | b;
         6: r = a ^ b;
         7: r = ($signed(a) < $signed(b)) ? a : b;
         8: r = ($signed(a) > $signed(b)) ? a : b;
         9: r = (a < b) ? a : b;
         10: r = (a > b) ? a : b;
         11: r = a << s;
         12: begin r = a >> s; if (a[31]) r = r | ~(32'hFFFF_FFFF >> s); end
         13: r = a >> s;
         14: r = (a != 0) ? b : c;
         15: r = a[31] ? (~a + 32'd1) : a;
         16: r = ((a > b) ? (a - b) : (b - a)) + c;
         default: r = 32'd0;
      endcase
      return r;
   endfunction

   function automatic logic [127:0] ref_vec(int op, logic [127:0] a, logic [127:0] b,
                                            logic [127:0] c);
      logic [127:0] r;
      for (int l = 0; l < 4; l++)
         r[l*32 +: 32] = ref_lane(op, a[l*32 +: 32], b[l*32 +: 32], c[l*32 +: 32], b[4:0]);
      return r;
   endfunction

   function automatic string req_of(int op);
      if (op == 0) return "R1";
      if (op <= 2) return "R2";
      if (op <= 6) return "R3";
      if (op <= 10) return "R4";
      if (op == 11) return "R5";
      if (op <= 13) return "R6";
      if (op == 14) return "R7";
      if (op == 15) return "R8";
      if (op == 16) return "R9";
      return "R10";
   endfunction

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Present one request, then check the registered result (R11) and an idle hold (R12).
   task automatic run_op(int op, logic [127:0] a, logic [127:0] b, logic [127:0] c, bit hold_chk);
      logic [127:0] exp;
      exp = ref_vec(op, a, b, c);
      @(negedge clk);
      in_valid = 1'b1; opcode = op[4:0]; src_a = a; src_b = b; src_c = c;
      @(negedge clk);
      in_valid = 1'b0;
      src_a = ~a; src_b = ~b; src_c = ~c;
      check(req_of(op), result, exp);
      check("R11", {127'd0, out_valid}, 128'd1);
      if (hold_chk) begin
         @(negedge clk);
         check("R12", result, exp);
         check("R11", {127'd0, out_valid}, 128'd0);
      end
   endtask

   function automatic logic [127:0] rnd_vec();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R11 watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1357_2468));
      repeat (3) @(negedge clk);
      check("R12", result, 128'd0);
      check("R12", {127'd0, out_valid}, 128'd0);
      rst_n = 1'b1;

      // R1 wrap, no carry across lanes
      run_op(0, {32'd5, 32'h7FFF_FFFF, 32'd0, 32'hFFFF_FFFF},
                {32'd7, 32'd1, 32'd0, 32'd1}, 128'd0, 1'b1);
      // R2 multiply low bits, and multiply-add with negative operands
      run_op(1, {4{32'h0001_0000}}, {4{32'h0001_0000}}, 128'd0, 1'b0);
      run_op(2, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFE}}, {4{32'd3}}, 1'b0);
      // R4 signed versus unsigned ordering
      run_op(7, {4{32'hFFFF_FFFF}}, {4{32'd1}}, 128'd0, 1'b0);
      run_op(9, {4{32'hFFFF_FFFF}}, {4{32'd1}}, 128'd0, 1'b0);
      run_op(8, {4{32'h8000_0000}}, {4{32'h7FFF_FFFF}}, 128'd0, 1'b0);
      run_op(10, {4{32'h8000_0000}}, {4{32'h7FFF_FFFF}}, 128'd0, 1'b0);
      // R5 amount from x lane only, wraps modulo 32; other lanes of src_b are large
      run_op(11, {4{32'h0000_0003}}, {32'hFFFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF, 32'd33}, 128'd0, 1'b1);
      run_op(13, {4{32'h8000_0000}}, {32'd7, 32'd9, 32'd0, 32'd63}, 128'd0, 1'b0);
      // R6 sign extension versus zero fill
      run_op(12, {4{32'h8000_0000}}, {96'd0, 32'd31}, 128'd0, 1'b0);
      run_op(13, {4{32'h8000_0000}}, {96'd0, 32'd31}, 128'd0, 1'b0);
      // R7 select per lane
      run_op(14, {32'd0, 32'd1, 32'd0, 32'h8000_0000}, {4{32'hAAAA_AAAA}}, {4{32'h5555_5555}}, 1'b0);
      // R8 most negative value wraps to itself
      run_op(15, {32'h8000_0000, 32'hFFFF_FFFF, 32'd5, 32'h8000_0001}, 128'd0, 128'd0, 1'b0);
      // R9 unsigned absolute difference plus addend
      run_op(16, {32'd3, 32'hFFFF_FFFF, 32'd10, 32'd0}, {32'd10, 32'd0, 32'd3, 32'hFFFF_FFFF},
             {32'd1, 32'd1, 32'd0, 32'd2}, 1'b0);
      // R10 unused opcodes
      run_op(20, rnd_vec(), rnd_vec(), rnd_vec(), 1'b1);
      run_op(31, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0);
      // R3 bitwise group
      for (int op = 3; op <= 6; op++) run_op(op, rnd_vec(), rnd_vec(), rnd_vec(), 1'b0);

      // Random mix over all codes, including unused ones
      for (int i = 0; i < 600; i++)
         run_op(int'($urandom % 20), rnd_vec(), rnd_vec(), rnd_vec(), (i % 7) == 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule